// File: doc/BRIEF.md
# Disk Channel Interrupt Status Unit

This unit gathers the two interrupt causes of a single disk channel into one level-sensitive interrupt line. The causes are a completion event from the attached drive and a memory-bus fault seen by the channel's DMA engine. Each cause sets a sticky pending bit. Software enables causes through a write-one-to-set register and acknowledges them through a write-one-to-clear register. When a bus fault occurs, the unit also keeps the faulting bus address so that software can report it.

A second way to acknowledge exists. The channel tells the unit each time software reads the drive's status byte, and passes that byte along. If the byte shows the drive is no longer busy and reports a ready, seek-complete or error condition, the unit clears both pending bits by itself. This makes a status read double as an acknowledge.

Register access is a word-addressed port, with a one-cycle write strobe and a combinational read mux. The unit has no streaming data path, so every pin is a plain control or status pin and there is no back-pressure.

Top module: `irq_status_unit`

## Requirements
- R1: After reset, the pending bits, the enable bits, both error-address words and `irq_o` are all zero.
- R2: A one-cycle pulse on `dev_evt_i` sets pending bit 0, and a pulse on `dma_err_i` sets pending bit 1. Each bit stays set until cleared. The pending bits read back in bits 1:0 of word offset 3, and the upper bits read as zero.
- R3: Writing to word offset 5 sets every enable bit whose write-data bit (1:0) is 1. Zero bits leave their enable unchanged. The enables read back in bits 1:0 of offset 5.
- R4: `irq_o` is high exactly when some pending bit and its enable bit are both set, and it holds as a level for as long as that is true.
- R5: Writing to word offset 7 clears each pending bit whose write-data bit (1:0) is 1. Pending bits written with 0 are unchanged.
- R6: An event that arrives in the same cycle as a clear write or an automatic clear sets its pending bit. The event wins.
- R7: A bus-fault pulse that arrives while pending bit 1 is clear captures `dma_err_addr_i`. Bits 31:0 read at word offset 0 and bits 63:32 read at word offset 1.
- R8: While pending bit 1 is set, the captured address stays frozen through further faults. After bit 1 is cleared, the next fault captures again.
- R9: A drive-status read strobe clears both pending bits when the drive-status byte has bit 7 (busy) at 0 and at least one of bits 6, 4 or 0 at 1.
- R10: A drive-status read strobe whose byte has bit 7 set, or has none of bits 6, 4 and 0 set, leaves the pending bits unchanged.
- R11: Reads of word offsets 2, 4 and 6 return zero. Writes to offsets 0 through 4 and to offset 6 change neither the pending bits nor the enable bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_i | input | 1 | Register write strobe, one cycle |
| reg_addr_i | input | 3 | Word offset for read and write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| dev_evt_i | input | 1 | Drive completion event pulse |
| dma_err_i | input | 1 | DMA memory-bus fault pulse |
| dma_err_addr_i | input | 64 | Bus address of the fault, valid with `dma_err_i` |
| drv_stat_rd_i | input | 1 | Strobe: software is reading the drive status byte |
| drv_stat_i | input | 8 | Drive status byte being read |
| irq_o | output | 1 | Level interrupt request |

## Verification
On every cycle, assertions check four things: that an event always leaves its pending bit set on the next cycle, even against a clear; that a clear write without a competing event removes the bit; that enable bits never drop outside reset; and that the captured fault address changes only when bit 1 was clear. They also check that a status read with busy set disturbs nothing. The bench's scenarios are what show the register map: the offsets of each register, the zeros returned from unused offsets, and the split of the address into low and high words. They also cover the exact mask decode of the automatic clear, and recapture of the fault address once bit 1 has been acknowledged.

// File: rtl/irqstat_pkg.sv
package irqstat_pkg;
  localparam int unsigned NSRC       = 2;
  localparam int unsigned SRC_DEV    = 0;
  localparam int unsigned SRC_BUSERR = 1;
  localparam int unsigned REG_AW     = 3;

  localparam logic [REG_AW-1:0] OFF_ADDR_LO = 3'd0;
  localparam logic [REG_AW-1:0] OFF_ADDR_HI = 3'd1;
  localparam logic [REG_AW-1:0] OFF_STATUS  = 3'd3;
  localparam logic [REG_AW-1:0] OFF_ENABLE  = 3'd5;
  localparam logic [REG_AW-1:0] OFF_CLEAR   = 3'd7;
endpackage

// File: rtl/irqstat_regdec.sv
module irqstat_regdec
  import irqstat_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ERR_AW = 64
) (
  input  logic              wr,
  input  logic [REG_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NSRC-1:0]   status,
  input  logic [NSRC-1:0]   enable,
  input  logic [ERR_AW-1:0] err_addr,
  output logic [NSRC-1:0]   en_set,
  output logic [NSRC-1:0]   clr_wr,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned EXT_W = 2 * DATA_W;

  logic [EXT_W-1:0] addr_ext;
  assign addr_ext = EXT_W'(err_addr);

  // Write decode: only the enable and clear offsets have a write effect
  assign en_set = (wr && addr == OFF_ENABLE) ? wdata[NSRC-1:0] : '0;
  assign clr_wr = (wr && addr == OFF_CLEAR)  ? wdata[NSRC-1:0] : '0;

  always_comb begin
    rdata = '0;
    case (addr)
      OFF_ADDR_LO: rdata = addr_ext[DATA_W-1:0];
      OFF_ADDR_HI: rdata = addr_ext[EXT_W-1:DATA_W];
      OFF_STATUS:  rdata = DATA_W'(status);
      OFF_ENABLE:  rdata = DATA_W'(enable);
      default:     rdata = '0;
    endcase
  end
endmodule

// File: rtl/irqstat_srcbits.sv
module irqstat_srcbits
  import irqstat_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_evt,
  input  logic [NSRC-1:0] clr_wr,
  input  logic            auto_clr,
  input  logic [NSRC-1:0] en_set,
  output logic [NSRC-1:0] status,
  output logic [NSRC-1:0] enable
);
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    // Pending bit: a new event outranks every clear path
    always_ff @(posedge clk) begin
      if (!rst_n)                     status[i] <= 1'b0;
      else if (set_evt[i])            status[i] <= 1'b1;
      else if (clr_wr[i] || auto_clr) status[i] <= 1'b0;
    end

    // Enable bit: write-one-to-set, only reset drops it
    always_ff @(posedge clk) begin
      if (!rst_n)         enable[i] <= 1'b0;
      else if (en_set[i]) enable[i] <= 1'b1;
    end

    assert_event_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt[i] |=> status[i]);

    assert_clear_takes_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr[i] && !set_evt[i]) |=> !status[i]);

    assert_enable_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      enable[i] |=> enable[i]);
  end
endmodule

// File: rtl/irqstat_errcap.sv
module irqstat_errcap #(
  parameter int unsigned ERR_AW = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_evt,
  input  logic              pending,
  input  logic [ERR_AW-1:0] addr_in,
  output logic [ERR_AW-1:0] addr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)                   addr_q <= '0;
    else if (err_evt && !pending) addr_q <= addr_in;
  end

  assert_capture_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt && !pending) |=> (addr_q == $past(addr_in)));

  assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pending) |-> $stable(addr_q));
endmodule

// File: rtl/irqstat_autoclr.sv
module irqstat_autoclr #(
  parameter int unsigned      DRV_W     = 8,
  parameter logic [DRV_W-1:0] AUTO_MASK = 8'h51,
  parameter int unsigned      BUSY_BIT  = 7
) (
  input  logic             rd,
  input  logic [DRV_W-1:0] stat,
  output logic             hit
);
  assign hit = rd && !stat[BUSY_BIT] && (|(stat & AUTO_MASK));
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irqstat_pkg::*;
#(
  parameter int unsigned      DATA_W    = 32,
  parameter int unsigned      ERR_AW    = 64,
  parameter int unsigned      DRV_W     = 8,
  parameter logic [DRV_W-1:0] AUTO_MASK = 8'h51,
  parameter int unsigned      BUSY_BIT  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              dev_evt_i,
  input  logic              dma_err_i,
  input  logic [ERR_AW-1:0] dma_err_addr_i,
  input  logic              drv_stat_rd_i,
  input  logic [DRV_W-1:0]  drv_stat_i,
  output logic              irq_o
);
  logic [NSRC-1:0]   status, enable, en_set, clr_wr, set_evt;
  logic [ERR_AW-1:0] err_addr;
  logic              auto_hit;

  always_comb begin
    set_evt             = '0;
    set_evt[SRC_DEV]    = dev_evt_i;
    set_evt[SRC_BUSERR] = dma_err_i;
  end

  irqstat_regdec #(.DATA_W(DATA_W), .ERR_AW(ERR_AW)) u_regdec (
    .wr(reg_wr_i), .addr(reg_addr_i), .wdata(reg_wdata_i),
    .status(status), .enable(enable), .err_addr(err_addr),
    .en_set(en_set), .clr_wr(clr_wr), .rdata(reg_rdata_o)
  );

  irqstat_autoclr #(.DRV_W(DRV_W), .AUTO_MASK(AUTO_MASK), .BUSY_BIT(BUSY_BIT)) u_autoclr (
    .rd(drv_stat_rd_i), .stat(drv_stat_i), .hit(auto_hit)
  );

  irqstat_srcbits u_srcbits (
    .clk(clk), .rst_n(rst_n), .set_evt(set_evt), .clr_wr(clr_wr),
    .auto_clr(auto_hit), .en_set(en_set), .status(status), .enable(enable)
  );

  irqstat_errcap #(.ERR_AW(ERR_AW)) u_errcap (
    .clk(clk), .rst_n(rst_n), .err_evt(dma_err_i), .pending(status[SRC_BUSERR]),
    .addr_in(dma_err_addr_i), .addr_q(err_addr)
  );

  assign irq_o = |(status & enable);

  // A status read while the drive is busy must not acknowledge anything
  assert_busy_no_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_stat_rd_i && drv_stat_i[BUSY_BIT] && !reg_wr_i && !dev_evt_i && !dma_err_i)
      |=> $stable(status));
endmodule

// File: tb/irq_status_unit_bench.sv
module irq_status_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        dev_evt_i = 1'b0;
  logic        dma_err_i = 1'b0;
  logic [63:0] dma_err_addr_i = '0;
  logic        drv_stat_rd_i = 1'b0;
  logic [7:0]  drv_stat_i = '0;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_unit u_irq_status_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .dev_evt_i(dev_evt_i),
    .dma_err_i(dma_err_i), .dma_err_addr_i(dma_err_addr_i),
    .drv_stat_rd_i(drv_stat_rd_i), .drv_stat_i(drv_stat_i), .irq_o(irq_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    reg_addr_i = a;
    #1;
    v = reg_rdata_o;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic events(input logic dev, input logic err, input logic [63:0] ea);
    @(negedge clk);
    dev_evt_i = dev; dma_err_i = err; dma_err_addr_i = ea;
    @(negedge clk);
    dev_evt_i = 1'b0; dma_err_i = 1'b0;
  endtask

  task automatic stat_read(input logic [7:0] s);
    @(negedge clk);
    drv_stat_rd_i = 1'b1; drv_stat_i = s;
    @(negedge clk);
    drv_stat_rd_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd3, v); check("R1 status", v, 0);
    rd(3'd5, v); check("R1 enable", v, 0);
    rd(3'd0, v); check("R1 addr lo", v, 0);
    rd(3'd1, v); check("R1 addr hi", v, 0);
    check("R1 irq", irq_o, 0);
  endtask

  task automatic t_latch_enable_clear();
    logic [31:0] v;
    events(1'b1, 1'b0, '0);
    rd(3'd3, v); check("R2 dev bit", v, 32'h1);
    check("R4 irq masked", irq_o, 0);
    wr(3'd5, 32'h1);
    rd(3'd5, v); check("R3 enable set", v, 32'h1);
    check("R4 irq level", irq_o, 1);
    repeat (3) @(negedge clk);
    check("R4 irq held", irq_o, 1);
    wr(3'd5, 32'h0);
    rd(3'd5, v); check("R3 zero ignored", v, 32'h1);
    wr(3'd7, 32'h1);
    rd(3'd3, v); check("R5 clear", v, 0);
    check("R4 irq drops", irq_o, 0);
  endtask

  task automatic t_partial_clear();
    logic [31:0] v;
    wr(3'd5, 32'h3);
    events(1'b1, 1'b1, 64'h0);
    rd(3'd3, v); check("R2 both bits", v, 32'h3);
    wr(3'd7, 32'h2);
    rd(3'd3, v); check("R5 partial clear", v, 32'h1);
    check("R4 irq bit0 only", irq_o, 1);
    wr(3'd7, 32'h3);
    rd(3'd3, v); check("R5 clear both", v, 0);
  endtask

  task automatic t_errcap();
    logic [31:0] v;
    events(1'b0, 1'b1, 64'h1234_5678_9ABC_DEF0);
    rd(3'd0, v); check("R7 addr lo", v, 32'h9ABC_DEF0);
    rd(3'd1, v); check("R7 addr hi", v, 32'h1234_5678);
    events(1'b0, 1'b1, 64'hCAFE_0000_0000_BEEF);
    rd(3'd0, v); check("R8 frozen lo", v, 32'h9ABC_DEF0);
    rd(3'd1, v); check("R8 frozen hi", v, 32'h1234_5678);
    wr(3'd7, 32'h2);
    events(1'b0, 1'b1, 64'hCAFE_0000_0000_BEEF);
    rd(3'd0, v); check("R8 recapture lo", v, 32'h0000_BEEF);
    rd(3'd1, v); check("R8 recapture hi", v, 32'hCAFE_0000);
    wr(3'd7, 32'h3);
  endtask

  task automatic t_race();
    logic [31:0] v;
    @(negedge clk);
    reg_wr_i = 1'b1; reg_addr_i = 3'd7; reg_wdata_i = 32'h3; dev_evt_i = 1'b1;
    @(negedge clk);
    reg_wr_i = 1'b0; dev_evt_i = 1'b0;
    rd(3'd3, v); check("R6 event beats clear write", v, 32'h1);
    @(negedge clk);
    drv_stat_rd_i = 1'b1; drv_stat_i = 8'h50; dma_err_i = 1'b1;
    @(negedge clk);
    drv_stat_rd_i = 1'b0; dma_err_i = 1'b0;
    rd(3'd3, v); check("R6 event beats auto clear", v, 32'h2);
    wr(3'd7, 32'h3);
  endtask

  task automatic t_auto();
    logic [31:0] v;
    events(1'b1, 1'b1, '0);
    stat_read(8'hD1);
    rd(3'd3, v); check("R10 busy blocks", v, 32'h3);
    stat_read(8'h2E);
    rd(3'd3, v); check("R10 no mask bit", v, 32'h3);
    stat_read(8'h40);
    rd(3'd3, v); check("R9 bit6 clears", v, 0);
    events(1'b1, 1'b1, '0);
    stat_read(8'h10);
    rd(3'd3, v); check("R9 bit4 clears", v, 0);
    events(1'b1, 1'b0, '0);
    stat_read(8'h01);
    rd(3'd3, v); check("R9 bit0 clears", v, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(3'd3, 32'h3);
    rd(3'd3, v); check("R11 status write ignored", v, 0);
    events(1'b1, 1'b0, '0);
    for (int a = 0; a < 7; a++) begin
      if (a != 5) wr(3'(a), 32'hFFFF_FFFF);
    end
    rd(3'd3, v); check("R11 status kept", v, 32'h1);
    rd(3'd5, v); check("R11 enable kept", v, 32'h3);
    rd(3'd2, v); check("R11 read 2", v, 0);
    rd(3'd4, v); check("R11 read 4", v, 0);
    rd(3'd6, v); check("R11 read 6", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latch_enable_clear();
    t_partial_clear();
    t_errcap();
    t_race();
    t_auto();
    t_unmapped();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule